// File: doc/BRIEF.md
# Linear CCD Line Readout Timing Generator

This block drives a two-output linear CCD sensor from one fast system clock. It sequences the sensor one line at a time. A line starts with a transfer window: the transfer gate pulse moves charge from the photocells into the two shift registers, with guard intervals on either side. A readout phase follows, with one shift-clock period for each pixel pair. Odd pixels leave on one sensor output and even pixels on the other, in phase. One shift period therefore delivers two pixels, and the pixel rate is twice the shift-clock rate.

The block produces complementary shift clocks `phi1` and `phi2`, plus a last-stage clock `phi2_last`. That clock has the same logical waveform as `phi2` but a separate pin, so it can be given its own driver. Each shift half-period carries a reset-gate pulse. The clamp pulse runs in one of two modes. In per-pixel mode it follows every reset pulse. In per-line mode it fires once per line, inside the optical-black region. For the converter side, the block gives a one-cycle sample strobe for each pixel pair, a start-of-line flag and a two-bit region tag.

All widths, delays and gaps are counts of system-clock cycles, taken from configuration inputs. The block copies them into internal registers only at the line boundary. A zero value is widened to one cycle where noted below. Each region's pixel count must be even.

Top module: `ccd_line_timer`

## Requirements
- R1: Each line has exactly one `tg` high pulse, lasting `cfg_tg_width` cycles (0 acts as 1).
- R2: `phi1` is high, with `phi2` low, for at least `cfg_guard` cycles before `tg` rises. After `tg` falls, `phi1` stays high for exactly `cfg_guard` cycles before readout starts (0 acts as 1).
- R3: `rs` and `cp` are low whenever `tg` is high, and during the guard after it.
- R4: During readout, `phi2` is high for `cfg_half` cycles and then low for `cfg_half` cycles, once for each pixel pair (0 acts as 1). `phi1` is always the inverse of `phi2`, and `phi2_last` always equals `phi2`. A line has (OB_PIX+LEAD_PIX+VALID_PIX+TRAIL_PIX)/2 pairs.
- R5: `rs` pulses once in every shift half-period. It rises `cfg_rs_delay` cycles after the `phi2` transition and is high for `cfg_rs_width` cycles (0 acts as 1 for both).
- R6: With `cfg_line_clamp`=0, `cp` pulses once in every half-period and is high for `cfg_cp_width` cycles (0 acts as 1). It rises after `rs` has been low for max(`cfg_cp_gap`, effective reset width) cycles.
- R7: With `cfg_line_clamp`=1, `cp` pulses exactly once per line, for `cfg_cp_width` cycles. It rises together with `phi2` of pair `cfg_clamp_pair` (pairs counted from 0), so exactly `cfg_clamp_pair` strobes come before it in that line.
- R8: `sample_stb` is high for one cycle per pair, in the last `phi2`-high cycle of that pair. It fires once for each pair of the line.
- R9: `line_start` is high only together with the first `sample_stb` of a line.
- R10: `region` qualifies each strobe. It reads 2'b00 for the first OB_PIX/2 pairs, 2'b01 for the next LEAD_PIX/2 pairs, 2'b10 for the next VALID_PIX/2 pairs and 2'b11 for the last TRAIL_PIX/2 pairs.
- R11: Configuration inputs are sampled only at the line boundary. A change made during readout has no effect until the next line.
- R12: During reset, `tg`, `phi2`, `phi2_last`, `rs`, `cp`, `sample_stb` and `line_start` are low and `phi1` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_tg_width | input | CW | Transfer gate high time, cycles |
| cfg_guard | input | CW | `phi1` hold time around the transfer gate, cycles |
| cfg_half | input | CW | Shift half-period, cycles |
| cfg_rs_delay | input | CW | Delay from `phi2` transition to reset rise |
| cfg_rs_width | input | CW | Reset pulse width |
| cfg_cp_gap | input | CW | Low gap between reset fall and clamp rise |
| cfg_cp_width | input | CW | Clamp pulse width |
| cfg_line_clamp | input | 1 | 0 = clamp every pixel, 1 = clamp once per line |
| cfg_clamp_pair | input | PW | Pair index of the per-line clamp |
| tg | output | 1 | Transfer gate pulse |
| phi1 | output | 1 | Shift clock 1 |
| phi2 | output | 1 | Shift clock 2 |
| phi2_last | output | 1 | Last-stage shift clock, separate driver |
| rs | output | 1 | Reset gate pulse |
| cp | output | 1 | Clamp pulse |
| sample_stb | output | 1 | Converter sample strobe, one per pair |
| line_start | output | 1 | First strobe of a line |
| region | output | 2 | Region tag of the strobed pair |

## Verification
Every output is decoded in the same cycle from the registered state and counter. A configuration value therefore shows up one line later, and a pulse edge falls a fixed number of cycles after the `phi2` transition it is timed from. The bench samples on the falling clock edge and measures in cycles. It counts run lengths of each signal, and the distance from a `phi2` rise to the next `rs` rise and from an `rs` fall to the next `cp` rise. It compares each figure with the configured count.

Each new configuration is applied at a transfer-gate rise. The first line that follows is thrown away, because it may still carry the old settings, and only the line after it is checked. The reload test changes the half-period in the middle of a line. It expects the old value for every remaining pair of that line and the new value on the next line.

// File: rtl/ccd_line_timer.sv
`timescale 1ns/1ps
module ccd_line_timer #(
  parameter int CW = 8,
  parameter int OB_PIX = 96,
  parameter int LEAD_PIX = 6,
  parameter int VALID_PIX = 7400,
  parameter int TRAIL_PIX = 6,
  localparam int NPAIRS = (OB_PIX + LEAD_PIX + VALID_PIX + TRAIL_PIX) / 2,
  localparam int PW = $clog2(NPAIRS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_tg_width,
  input  logic [CW-1:0] cfg_guard,
  input  logic [CW-1:0] cfg_half,
  input  logic [CW-1:0] cfg_rs_delay,
  input  logic [CW-1:0] cfg_rs_width,
  input  logic [CW-1:0] cfg_cp_gap,
  input  logic [CW-1:0] cfg_cp_width,
  input  logic          cfg_line_clamp,
  input  logic [PW-1:0] cfg_clamp_pair,
  output logic          tg,
  output logic          phi1,
  output logic          phi2,
  output logic          phi2_last,
  output logic          rs,
  output logic          cp,
  output logic          sample_stb,
  output logic          line_start,
  output logic [1:0]    region
);
  localparam logic [PW-1:0] LAST_PAIR   = PW'(NPAIRS - 1);
  localparam logic [PW-1:0] LEAD_START  = PW'(OB_PIX / 2);
  localparam logic [PW-1:0] VALID_START = PW'((OB_PIX + LEAD_PIX) / 2);
  localparam logic [PW-1:0] TRAIL_START = PW'((OB_PIX + LEAD_PIX + VALID_PIX) / 2);

  typedef enum logic [2:0] {S_LOAD, S_PRE, S_TG, S_POST, S_SHIFT} state_t;

  state_t        st;
  logic [CW-1:0] cnt, span;
  logic [CW-1:0] sh_tgw, sh_guard, sh_half, sh_rsd, sh_rsw, sh_gap, sh_cpw;
  logic          sh_line, half_b;
  logic [PW-1:0] sh_lcp, pair;

  function automatic logic [CW-1:0] at_least1(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  wire [CW-1:0] rsw_in = at_least1(cfg_rs_width);

  always_comb begin
    case (st)
      S_PRE, S_POST: span = sh_guard;
      S_TG:          span = sh_tgw;
      S_SHIFT:       span = sh_half;
      default:       span = CW'(1);
    endcase
  end

  wire last = (cnt == span - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_LOAD;
      cnt      <= '0;
      half_b   <= 1'b0;
      pair     <= '0;
      sh_tgw   <= CW'(1);
      sh_guard <= CW'(1);
      sh_half  <= CW'(1);
      sh_rsd   <= CW'(1);
      sh_rsw   <= CW'(1);
      sh_gap   <= CW'(1);
      sh_cpw   <= CW'(1);
      sh_line  <= 1'b0;
      sh_lcp   <= '0;
    end else begin
      if (st == S_LOAD) begin
        sh_tgw   <= at_least1(cfg_tg_width);
        sh_guard <= at_least1(cfg_guard);
        sh_half  <= at_least1(cfg_half);
        sh_rsd   <= at_least1(cfg_rs_delay);
        sh_rsw   <= rsw_in;
        sh_gap   <= (cfg_cp_gap > rsw_in) ? cfg_cp_gap : rsw_in;
        sh_cpw   <= at_least1(cfg_cp_width);
        sh_line  <= cfg_line_clamp;
        sh_lcp   <= cfg_clamp_pair;
      end
      if (!last) cnt <= cnt + CW'(1);
      else begin
        cnt <= '0;
        case (st)
          S_LOAD: st <= S_PRE;
          S_PRE:  st <= S_TG;
          S_TG:   st <= S_POST;
          S_POST: begin
            st     <= S_SHIFT;
            half_b <= 1'b0;
            pair   <= '0;
          end
          default: begin
            half_b <= ~half_b;
            if (half_b) begin
              if (pair == LAST_PAIR) st <= S_LOAD;
              else pair <= pair + PW'(1);
            end
          end
        endcase
      end
    end
  end

  wire shifting = (st == S_SHIFT);
  wire [CW+1:0] c      = {2'b00, cnt};
  wire [CW+1:0] rs_on  = {2'b00, sh_rsd};
  wire [CW+1:0] rs_off = rs_on + {2'b00, sh_rsw};
  wire [CW+1:0] cp_on  = rs_off + {2'b00, sh_gap};
  wire [CW+1:0] cp_off = cp_on + {2'b00, sh_cpw};

  wire cp_pix  = (c >= cp_on) && (c < cp_off);
  wire cp_once = !half_b && (pair == sh_lcp) && (c < {2'b00, sh_cpw});

  assign tg         = (st == S_TG);
  assign phi2       = shifting && !half_b;
  assign phi1       = !phi2;
  assign phi2_last  = shifting && !half_b;
  assign rs         = shifting && (c >= rs_on) && (c < rs_off);
  assign cp         = shifting && (sh_line ? cp_once : cp_pix);
  assign sample_stb = shifting && !half_b && last;
  assign line_start = sample_stb && (pair == '0);
  assign region     = (pair < LEAD_START)  ? 2'b00 :
                      (pair < VALID_START) ? 2'b01 :
                      (pair < TRAIL_START) ? 2'b10 : 2'b11;

  p_tg_quiet_r3: assert property (@(posedge clk) disable iff (rst) tg |-> !rs && !cp);
  p_tg_rise_r2: assert property (@(posedge clk) disable iff (rst) $rose(tg) |-> phi1 && $past(phi1));
  p_tg_fall_r2: assert property (@(posedge clk) disable iff (rst) $fell(tg) |-> phi1 && !phi2);
  p_rs_after_edge_r5: assert property (@(posedge clk) disable iff (rst) $rose(rs) |-> $stable(phi2));
  p_cp_clear_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cp) && !sh_line) |-> !rs && !$past(rs));
  p_stb_single_r8: assert property (@(posedge clk) disable iff (rst) sample_stb |=> !sample_stb);
  p_ls_first_r9: assert property (@(posedge clk) disable iff (rst) line_start |-> sample_stb && region == 2'b00);
endmodule

// File: tb/test_ccd_line_timer.sv
`timescale 1ns/1ps
module test_ccd_line_timer;
  localparam int CW = 8, OB = 8, LEAD = 2, VAL = 12, TRL = 2;
  localparam int NP = (OB + LEAD + VAL + TRL) / 2;
  localparam int PW = $clog2(NP);

  typedef struct packed {
    logic [CW-1:0] tgw, guard, half, rsd, rsw, cpg, cpw;
    logic          line;
    logic [PW-1:0] lcp;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'd5,  8'd3, 8'd8,  8'd1, 8'd2, 8'd1, 8'd2, 1'b0, 4'd0},
    '{8'd12, 8'd4, 8'd10, 8'd2, 8'd1, 8'd3, 8'd3, 1'b0, 4'd0},
    '{8'd6,  8'd2, 8'd6,  8'd1, 8'd2, 8'd0, 8'd4, 1'b1, 4'd3},
    '{8'd0,  8'd0, 8'd4,  8'd0, 8'd0, 8'd0, 8'd0, 1'b0, 4'd0}};

  logic clk = 1'b0, rst = 1'b1;
  vec_t cur;
  logic tg, phi1, phi2, phi2_last, rs, cp, sample_stb, line_start;
  logic [1:0] region;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  ccd_line_timer #(.CW(CW), .OB_PIX(OB), .LEAD_PIX(LEAD), .VALID_PIX(VAL), .TRAIL_PIX(TRL)) i_ccd_line_timer (
    .clk(clk), .rst(rst),
    .cfg_tg_width(cur.tgw), .cfg_guard(cur.guard), .cfg_half(cur.half),
    .cfg_rs_delay(cur.rsd), .cfg_rs_width(cur.rsw), .cfg_cp_gap(cur.cpg),
    .cfg_cp_width(cur.cpw), .cfg_line_clamp(cur.line), .cfg_clamp_pair(cur.lcp),
    .tg(tg), .phi1(phi1), .phi2(phi2), .phi2_last(phi2_last), .rs(rs), .cp(cp),
    .sample_stb(sample_stb), .line_start(line_start), .region(region));

  function automatic int e1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  int m_tg, m_pre, m_post, m_run_min, m_run_max, m_rises, m_phase_bad, m_quiet_bad;
  int m_rs_n, m_rs_w, m_rs_d, m_cp_n, m_cp_w, m_cp_gap, m_cp_stb, m_stb, m_stb_bad, m_ls_n, m_ls_bad;
  int m_rg [4];

  task automatic measure_line(input int new_half, input int exp_half);
    int run, hi, lo, rsd_cnt, gap_cnt, limit;
    logic p2_prev, rs_prev, cp_prev, rsd_on, gap_on, changed;
    m_tg = 0; m_pre = 0; m_post = 0; m_run_min = 1000; m_run_max = 0; m_rises = 0;
    m_phase_bad = 0; m_quiet_bad = 0; m_rs_n = 0; m_rs_w = 0; m_rs_d = -1; m_cp_n = 0;
    m_cp_w = 0; m_cp_gap = -1; m_cp_stb = -1; m_stb = 0; m_stb_bad = 0; m_ls_n = 0; m_ls_bad = 0;
    for (int k = 0; k < 4; k++) m_rg[k] = 0;
    limit = 0;
    while (tg !== 1'b1 && limit < 2000) begin @(negedge clk); limit++; end
    while (tg === 1'b1 && limit < 2000) begin
      m_tg++;
      if (rs || cp) m_quiet_bad++;
      @(negedge clk); limit++;
    end
    while (phi1 && !tg && limit < 2000) begin
      m_post++;
      if (rs || cp) m_quiet_bad++;
      @(negedge clk); limit++;
    end
    p2_prev = 0; rs_prev = 0; cp_prev = 0; hi = 0; lo = 0; run = 0;
    rsd_cnt = 0; gap_cnt = 0; rsd_on = 0; gap_on = 0; changed = 0;
    while (tg !== 1'b1 && limit < 2000) begin
      if (phi1 !== !phi2 || phi2_last !== phi2) m_phase_bad++;
      run = (phi1 && !phi2) ? run + 1 : 0;
      if (phi2 && !p2_prev) begin
        m_rises++;
        if (lo > 0) begin
          if (lo < m_run_min) m_run_min = lo;
          if (lo > m_run_max) m_run_max = lo;
        end
        lo = 0; rsd_cnt = 0; rsd_on = (m_rs_n == 0);
      end
      if (!phi2 && p2_prev) begin
        if (hi < m_run_min) m_run_min = hi;
        if (hi > m_run_max) m_run_max = hi;
        hi = 0;
        if (!changed && new_half > 0) begin cur.half = CW'(new_half); changed = 1; end
      end
      if (phi2) hi++; else lo++;
      if (rs && !rs_prev) begin
        m_rs_n++;
        if (rsd_on) begin m_rs_d = rsd_cnt; rsd_on = 0; end
      end
      if (rsd_on && !rs) rsd_cnt++;
      if (rs && m_rs_n == 1) m_rs_w++;
      if (!rs && rs_prev && m_rs_n == 1) begin gap_on = 1; gap_cnt = 0; end
      if (cp && !cp_prev) begin
        m_cp_n++;
        if (gap_on) begin m_cp_gap = gap_cnt; gap_on = 0; end
        if (m_cp_n == 1) m_cp_stb = m_stb;
      end
      if (gap_on && !cp) gap_cnt++;
      if (cp && m_cp_n == 1) m_cp_w++;
      if (sample_stb) begin
        m_stb++;
        m_rg[region]++;
        if (!phi2 || hi != exp_half) m_stb_bad++;
      end
      if (line_start) begin
        m_ls_n++;
        if (!sample_stb || m_stb != 1) m_ls_bad++;
      end
      p2_prev = phi2; rs_prev = rs; cp_prev = cp;
      @(negedge clk); limit++;
    end
    m_pre = run;
  endtask

  task automatic check_vec(input vec_t v);
    int h, rw;
    h = e1(int'(v.half));
    rw = e1(int'(v.rsw));
    chk("R1 tg width", m_tg, e1(int'(v.tgw)));
    chk("R2 guard after tg", m_post, e1(int'(v.guard)));
    chk("R2 guard before tg", int'(m_pre >= e1(int'(v.guard))), 1);
    chk("R3 rs/cp quiet in transfer window", m_quiet_bad, 0);
    chk("R4 shortest phase run", m_run_min, h);
    chk("R4 longest phase run", m_run_max, h);
    chk("R4 pairs per line", m_rises, NP);
    chk("R4 phi1/phi2/phi2_last relation", m_phase_bad, 0);
    chk("R5 rs pulses per line", m_rs_n, 2 * NP);
    chk("R5 rs width", m_rs_w, rw);
    chk("R5 rs delay", m_rs_d, e1(int'(v.rsd)));
    if (!v.line) begin
      chk("R6 cp pulses per line", m_cp_n, 2 * NP);
      chk("R6 cp width", m_cp_w, e1(int'(v.cpw)));
      chk("R6 rs-to-cp gap", m_cp_gap, (int'(v.cpg) > rw) ? int'(v.cpg) : rw);
    end else begin
      chk("R7 cp pulses per line", m_cp_n, 1);
      chk("R7 cp width", m_cp_w, e1(int'(v.cpw)));
      chk("R7 cp pair index", m_cp_stb, int'(v.lcp));
    end
    chk("R8 strobes per line", m_stb, NP);
    chk("R8 strobe placement", m_stb_bad, 0);
    chk("R9 line_start count", m_ls_n, 1);
    chk("R9 line_start placement", m_ls_bad, 0);
    chk("R10 region 00 strobes", m_rg[0], OB / 2);
    chk("R10 region 01 strobes", m_rg[1], LEAD / 2);
    chk("R10 region 10 strobes", m_rg[2], VAL / 2);
    chk("R10 region 11 strobes", m_rg[3], TRL / 2);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL R1 watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur = VEC[0];
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 tg in reset", int'(tg), 0);
    chk("R12 phi1 in reset", int'(phi1), 1);
    chk("R12 phi2/phi2_last in reset", int'(phi2 | phi2_last), 0);
    chk("R12 rs/cp in reset", int'(rs | cp), 0);
    chk("R12 strobe/line_start in reset", int'(sample_stb | line_start), 0);
    rst = 1'b0;

    for (int i = 0; i < 4; i++) begin
      cur = VEC[i];
      measure_line(0, e1(int'(VEC[i].half)));
      measure_line(0, e1(int'(VEC[i].half)));
      check_vec(VEC[i]);
    end

    // R11: half-period changed in the middle of readout
    cur = VEC[0];
    measure_line(0, 8);
    measure_line(12, 8);
    chk("R11 old half kept, shortest", m_run_min, 8);
    chk("R11 old half kept, longest", m_run_max, 8);
    measure_line(0, 12);
    chk("R11 new half on next line", m_run_min, 12);
    chk("R11 new half on next line, longest", m_run_max, 12);
    chk("R11 strobes on next line", m_stb, NP);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule